// File: doc/BRIEF.md
# Frequency-Floored Square Wave Regenerator

This block takes a digitized square wave of varying rate and produces a 50%-duty square wave of the same rate, driven entirely by the system clock. It measures the spacing between input transitions in clock cycles. It then rebuilds each output high and low level from the latest measurement, so the output does not need to line up in phase with the input.

The output has a lower frequency limit. When the input slows below that limit, or stops toggling altogether, the output keeps running at the limit. A gap that grows past the floor ends the measurement early, so the output never waits on a stalled input. A new level length is only adopted at an output transition. As a result, every high and every low level is whole and uniform, including at the moment the block moves between tracking and holding the floor.

Both limits are parameters counted in clock cycles: the floor half-period and the shortest half-period accepted as real. Transitions spaced closer than the shortest half-period are treated as noise. With a 50 MHz clock, an 85 Hz floor is a half-period of 294118 cycles. Accepting up to 2.5 kHz with margin gives a shortest half-period of 8000 cycles.

Top module: `sqRegenTop`

## Requirements
- R1: While reset is asserted, `sqOut` is 0. After reset is released, the first output level lasts exactly FLOOR_HALF clock cycles. The first accepted input transition after reset only starts a measurement and never sets the output rate by itself.
- R2: With a steady input whose transitions are H cycles apart, where MIN_HALF <= H <= FLOOR_HALF, both the high and the low output levels settle to exactly H cycles. Rising and falling input transitions both count.
- R3: With a steady input whose transitions are more than FLOOR_HALF cycles apart, every output level settles to exactly FLOOR_HALF cycles.
- R4: With an input that never toggles, the output keeps toggling with every level exactly FLOOR_HALF cycles long.
- R5: An output level's length is fixed at the transition that starts it. No level is ever shorter than MIN_HALF or longer than FLOOR_HALF cycles. In a change from tracking to floor or from floor to tracking, every level equals either the old length or the new one.
- R6: An input transition fewer than MIN_HALF cycles after the last accepted transition is ignored. It does not restart the measurement, and it does not alter the stored length.
- R7: The gap counter stops at FLOOR_HALF. Once a gap reaches FLOOR_HALF cycles without a transition, the floor length is used from the next output transition on. With levels of 50 cycles, at most three such levels follow the input's last transition before levels of FLOOR_HALF begin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sigIn | input | 1 | Asynchronous digitized square wave to be followed |
| sqOut | output | 1 | Regenerated 50%-duty square wave |

## Verification
The bench builds the block with FLOOR_HALF = 100, MIN_HALF = 8 and SYNC_STAGES = 2. This shrinks the floor from hundreds of thousands of cycles to one hundred. Saturation of the gap counter, stalls, restarts and both directions of the floor transition therefore all happen within a few hundred cycles each. With MIN_HALF at 8, a bounce of two-cycle pulses right after a real transition lands clearly inside the rejection window. It also leaves input rates down to MIN_HALF itself open to the tracking checks.

// File: rtl/sqRegenPkg.sv
package sqRegenPkg;

  // Operating mode of the length selector
  typedef enum logic {
    MODE_FLOOR = 1'b0,
    MODE_TRACK = 1'b1
  } modeT;

  // Observations the datapath hands to control
  typedef struct packed {
    logic edgeSeen;    // synchronized input changed level this cycle
    logic gapShort;    // current gap would be below MIN_HALF
    logic gapAtFloor;  // current gap has reached FLOOR_HALF
    logic measSat;     // gap counter parked at FLOOR_HALF
    logic outDone;     // current output level ends this cycle
  } dpStatusT;

  // Strobes control issues to the datapath
  typedef struct packed {
    logic restartMeas; // start a fresh gap count
    logic loadMeas;    // store the finished gap as the new length
    logic saturate;    // park the gap counter at the floor
    logic flipOut;     // toggle the output and load the next length
    logic useFloor;    // next level uses the floor length
  } ctrlStrobeT;

endpackage

// File: rtl/sqRegenDatapath.sv
module sqRegenDatapath
  import sqRegenPkg::*;
#(
  parameter int FLOOR_HALF  = 294118,
  parameter int MIN_HALF    = 8000,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  ctrlStrobeT       strobe,
  output dpStatusT         status,
  output logic             sqOut,
  output logic [CNT_W-1:0] measCnt,
  output logic [CNT_W-1:0] lastHalf,
  output logic [CNT_W-1:0] halfLen,
  output logic [CNT_W-1:0] outCnt
);

  localparam logic [CNT_W-1:0] FLOOR_C   = CNT_W'(FLOOR_HALF);
  localparam logic [CNT_W-1:0] FLOOR_M1  = CNT_W'(FLOOR_HALF - 1);
  localparam logic [CNT_W-1:0] MIN_M1    = CNT_W'(MIN_HALF - 1);

  // Synchronizer chain plus one extra stage used for edge detection
  logic [SYNC_STAGES:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= sigIn;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= 1'b0;
      else       syncQ[g] <= syncQ[g-1];
    end
  end

  // Both polarities of input transition count as an edge
  assign status.edgeSeen   = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];
  assign status.gapShort   = (measCnt < MIN_M1);
  assign status.gapAtFloor = (measCnt >= FLOOR_M1);
  assign status.measSat    = (measCnt == FLOOR_C);
  assign status.outDone    = (outCnt == '0);

  // Gap counter: cycles since the last accepted edge, minus one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   measCnt <= '0;
    else if (strobe.restartMeas) measCnt <= '0;
    else if (strobe.saturate)    measCnt <= FLOOR_C;
    else if (!status.measSat)    measCnt <= measCnt + 1'b1;
  end

  // Most recent finished gap below the floor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lastHalf <= FLOOR_C;
    else if (strobe.loadMeas) lastHalf <= measCnt + 1'b1;
  end

  // Output generator: length picked only when a level begins
  logic [CNT_W-1:0] nextLen;
  assign nextLen = strobe.useFloor ? FLOOR_C : lastHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqOut   <= 1'b0;
      halfLen <= FLOOR_C;
      outCnt  <= FLOOR_M1;
    end else if (strobe.flipOut) begin
      sqOut   <= ~sqOut;
      halfLen <= nextLen;
      outCnt  <= nextLen - 1'b1;
    end else begin
      outCnt  <= outCnt - 1'b1;
    end
  end

endmodule

// File: rtl/sqRegenCtrl.sv
module sqRegenCtrl
  import sqRegenPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatusT   status,
  output ctrlStrobeT strobe
);

  modeT mode;
  logic primed;     // an accepted edge has opened a real measurement
  logic takeSample;

  // An edge counts only when the gap is long enough to be real
  assign takeSample = status.edgeSeen && !status.gapShort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= MODE_FLOOR;
      primed <= 1'b0;
    end else begin
      if (takeSample) begin
        primed <= 1'b1;
        if (primed && !status.gapAtFloor) mode <= MODE_TRACK;
        else if (status.gapAtFloor)       mode <= MODE_FLOOR;
      end else if (strobe.saturate) begin
        mode <= MODE_FLOOR;
      end
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.restartMeas = takeSample;
    strobe.loadMeas    = takeSample && primed && !status.gapAtFloor;
    strobe.saturate    = !status.edgeSeen && status.gapAtFloor && !status.measSat;
    strobe.flipOut     = status.outDone;
    strobe.useFloor    = (mode == MODE_FLOOR);
  end

endmodule

// File: rtl/sqRegenTop.sv
module sqRegenTop
  import sqRegenPkg::*;
#(
  parameter int FLOOR_HALF  = 294118,
  parameter int MIN_HALF    = 8000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic sqOut
);

  localparam int CNT_W = $clog2(FLOOR_HALF + 1);

  dpStatusT         status;
  ctrlStrobeT       strobe;
  logic [CNT_W-1:0] measCnt;
  logic [CNT_W-1:0] lastHalf;
  logic [CNT_W-1:0] halfLen;
  logic [CNT_W-1:0] outCnt;

  sqRegenDatapath #(
    .FLOOR_HALF (FLOOR_HALF),
    .MIN_HALF   (MIN_HALF),
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W)
  ) dp (
    .clk     (clk),
    .rstN    (rstN),
    .sigIn   (sigIn),
    .strobe  (strobe),
    .status  (status),
    .sqOut   (sqOut),
    .measCnt (measCnt),
    .lastHalf(lastHalf),
    .halfLen (halfLen),
    .outCnt  (outCnt)
  );

  sqRegenCtrl ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .status(status),
    .strobe(strobe)
  );

endmodule

// File: rtl/sqRegenChecker.sv
module sqRegenChecker #(
  parameter int FLOOR_HALF = 294118,
  parameter int MIN_HALF   = 8000,
  parameter int CNT_W      = 19
) (
  input logic             clk,
  input logic             rstN,
  input logic             sqOut,
  input logic             edgeSeen,
  input logic             gapShort,
  input logic             useFloor,
  input logic [CNT_W-1:0] measCnt,
  input logic [CNT_W-1:0] lastHalf,
  input logic [CNT_W-1:0] halfLen,
  input logic [CNT_W-1:0] outCnt
);

  localparam logic [CNT_W-1:0] FLOOR_C = CNT_W'(FLOOR_HALF);
  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_HALF);

  // Output only changes when the running level has used up its count
  assert_flip_at_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sqOut != $past(sqOut)) |-> ($past(outCnt) == '0));

  // The level length stays put between output transitions
  assert_len_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outCnt) != '0) |-> $stable(halfLen));

  // Every level lies between the noise limit and the floor
  assert_len_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (halfLen >= MIN_C) && (halfLen <= FLOOR_C));

  // The gap counter never runs past the floor
  assert_meas_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    measCnt <= FLOOR_C);

  // A parked gap counter always means floor operation
  assert_floor_when_parked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (measCnt == FLOOR_C) |-> useFloor);

  // Tracking mode only ever holds a length below the floor
  assert_track_below_floor_R2: assert property (@(posedge clk) disable iff (!rstN)
    !useFloor |-> (lastHalf < FLOOR_C));

  // A too-close edge leaves both the stored length and the count alone
  assert_noise_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSeen && gapShort) |=> ($stable(lastHalf) && (measCnt == $past(measCnt) + 1'b1)));

endmodule

bind sqRegenTop sqRegenChecker #(
  .FLOOR_HALF(FLOOR_HALF),
  .MIN_HALF  (MIN_HALF),
  .CNT_W     (CNT_W)
) chk (
  .clk     (clk),
  .rstN    (rstN),
  .sqOut   (sqOut),
  .edgeSeen(status.edgeSeen),
  .gapShort(status.gapShort),
  .useFloor(strobe.useFloor),
  .measCnt (measCnt),
  .lastHalf(lastHalf),
  .halfLen (halfLen),
  .outCnt  (outCnt)
);

// File: tb/sqRegenTop_test.sv
module sqRegenTop_test;

  localparam int FLOOR_HALF = 100;
  localparam int MIN_HALF   = 8;
  localparam int NVEC       = 10;
  // {input half-period (0 = stalled), expected output level length}
  localparam int VEC [NVEC][2] = '{
    '{20, 20}, '{50, 50}, '{8, 8}, '{99, 99}, '{100, 100},
    '{101, 100}, '{150, 100}, '{0, 100}, '{35, 35}, '{400, 100}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sigIn = 1'b0;
  logic sqOut;

  always #10 clk = ~clk;  // 50 MHz

  sqRegenTop #(
    .FLOOR_HALF (FLOOR_HALF),
    .MIN_HALF   (MIN_HALF),
    .SYNC_STAGES(2)
  ) uut (
    .clk  (clk),
    .rstN (rstN),
    .sigIn(sigIn),
    .sqOut(sqOut)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Input wave driver: toggles every curHalf cycles, optional bounce
  int curHalf = 0;
  int drvCnt = 0;
  bit bounceReq = 0;
  int bouncePh = 0;

  initial begin
    forever begin
      @(negedge clk);
      drvCnt++;
      if (bouncePh != 0) begin
        bouncePh++;
        if (bouncePh == 3 || bouncePh == 5) sigIn = ~sigIn;
        if (bouncePh == 5) bouncePh = 0;
      end
      if (curHalf != 0 && drvCnt >= curHalf) begin
        sigIn = ~sigIn;
        drvCnt = 0;
        if (bounceReq) begin
          bounceReq = 0;
          bouncePh = 1;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Length of the level that started at the current negedge
  task automatic levelFromHere(output int len);
    logic v;
    int n;
    v = sqOut;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sqOut == v);
    len = n;
  endtask

  // Wait for the next output transition, then measure that level
  task automatic measureLevel(output int len);
    logic v;
    v = sqOut;
    do @(negedge clk); while (sqOut == v);
    levelFromHere(len);
  endtask

  // Level-length monitor for R5: every whole level within limits
  logic prevOut = 1'b0;
  int runLen = 0;
  bit started = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      started = 0;
      runLen = 0;
      prevOut = sqOut;
    end else if (sqOut != prevOut) begin
      if (started) begin
        checks++;
        if (runLen < MIN_HALF || runLen > FLOOR_HALF) begin
          fails++;
          $display("FAIL R5 level length actual=%0d expected=%0d..%0d",
                   runLen, MIN_HALF, FLOOR_HALF);
        end
      end
      started = 1;
      runLen = 1;
      prevOut = sqOut;
    end else begin
      runLen++;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int a;
    int b;
    int n;
    int fastCnt;
    bit badSet;
    string tag;

    // R1: reset state and first level length
    repeat (3) @(negedge clk);
    chk("R1 output during reset", int'(sqOut), 0);
    rstN = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sqOut && n < 1000);
    chk("R1 first level after reset", n, FLOOR_HALF);
    levelFromHere(a);
    chk("R4 stalled from reset", a, FLOOR_HALF);

    // Table-driven rate checks (R2, R3, R4)
    for (int i = 0; i < NVEC; i++) begin
      curHalf = VEC[i][0];
      repeat (400) @(negedge clk);
      measureLevel(a);
      levelFromHere(b);
      if (VEC[i][0] == 0) tag = "R4 stalled input";
      else if (VEC[i][0] > FLOOR_HALF) tag = "R3 slow input";
      else tag = "R2 tracking";
      chk($sformatf("%s in=%0d first level", tag, VEC[i][0]), a, VEC[i][1]);
      chk($sformatf("%s in=%0d second level", tag, VEC[i][0]), b, VEC[i][1]);
    end

    // R6: bounce right after a real transition is ignored
    curHalf = 30;
    repeat (400) @(negedge clk);
    bounceReq = 1;
    while (bouncePh == 0) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      measureLevel(a);
      chk($sformatf("R6 level %0d after bounce", k), a, 30);
    end

    // R5 and R7: tracking 50 then the input stops
    curHalf = 50;
    repeat (400) @(negedge clk);
    curHalf = 0;
    fastCnt = 0;
    badSet = 0;
    measureLevel(a);
    for (int k = 0; k < 6; k++) begin
      if (a == 50) fastCnt++;
      else if (a != FLOOR_HALF) badSet = 1;
      if (k < 5) levelFromHere(a);
    end
    chk("R5 levels in {50,FLOOR} on slowdown", int'(badSet), 0);
    chk("R7 fast levels after stop at most 3", int'(fastCnt <= 3), 1);
    chk("R7 settles to floor after stop", a, FLOOR_HALF);

    // R5: from floor back to tracking at 20
    curHalf = 20;
    badSet = 0;
    measureLevel(a);
    for (int k = 0; k < 6; k++) begin
      if (a != 20 && a != FLOOR_HALF) badSet = 1;
      if (k < 5) levelFromHere(a);
    end
    chk("R5 levels in {FLOOR,20} on speedup", int'(badSet), 0);
    chk("R2 settles to 20 after restart", a, 20);

    // R1: reset while running, then floor first
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 output during mid-run reset", int'(sqOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sqOut && n < 1000);
    chk("R1 first level after mid-run reset", n, FLOOR_HALF);
    repeat (300) @(negedge clk);
    measureLevel(a);
    chk("R2 tracking after mid-run reset", a, 20);

    finished = 1;
    summary();
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
    end
  end

endmodule